// File: doc/BRIEF.md
# Standby Power Sequencer

This block walks a chip into a low-power standby state and back out again, one step at a time and in a fixed order. A start request begins the entry path. First the termination-off value is written to the DRAM extended mode register. Then the DRAM is put into self refresh and the DRAM controller is powered off. Next the system clock moves from the PLL to the crystal, the PLL is powered down, and clock deletion is switched on. The sequencer then sleeps until an interrupt arrives on a line chosen by a trigger mask, which is captured when the start is accepted.

On wake the steps are undone in reverse order: the PLL first, then clock deletion, the clock source, the DRAM controller and finally self refresh. A one-cycle done pulse marks the end of the exit path.

Every peripheral is reached through a level request and a level status input. A step moves on in the cycle after its status input reaches the expected level. A step whose status does not arrive in time ends the run with an error flag and returns every request to its run value.

Top module: `standby_seq`

## Requirements
- R1: After reset all outputs are low: no request is driven, `emr_data_o` is zero, and busy, done and error are clear.
- R2: A start in idle captures `trig_mask_i` and raises `emr_req_o` with `emr_data_o` equal to the `EMR_TERM_OFF` parameter. A start while busy is ignored, and the captured mask stays unchanged.
- R3: `sr_req_o` rises after `emr_ack_i` is seen high, and `ctl_pwr_off_o` rises after `sr_ack_i` is seen high. Each request output changes one clock edge after the edge that samples the awaited status, so a status arriving L cycles after its request gives a spacing of L+1 cycles.
- R4: `clk_xtal_sel_o` rises after `ctl_pwr_good_i` is seen low, and `pll_pwr_off_o` rises after `clk_xtal_ack_i` is seen high. The PLL is never off while the PLL is the selected clock.
- R5: `cdel_en_o` rises after `pll_lock_i` is seen low, and the sequencer then waits for wake. Clock deletion is only on while the crystal is selected.
- R6: In the wait state, the sequencer wakes on the clock edge at which `irq_i & captured_mask` is nonzero. Interrupt bits outside the mask have no effect.
- R7: On wake `pll_pwr_off_o` falls first, with the controller still off. `cdel_en_o` falls after `pll_lock_i` is seen high. `clk_xtal_sel_o` falls after `cdel_ack_i` is seen low.
- R8: `ctl_pwr_off_o` falls after `clk_xtal_ack_i` is seen low, and `sr_req_o` falls after `ctl_pwr_good_i` is seen high. `done_o` pulses for one cycle after `sr_ack_i` is seen low, and busy drops in that same cycle.
- R9: If a step's status has not reached its level TMO_CYC cycles after the step's request changed, `err_o` sets, busy drops and all requests return low. `err_o` clears when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin entry sequence (accepted in idle only) |
| trig_mask_i | input | IRQ_W | Wake line selection, captured at start |
| irq_i | input | IRQ_W | Interrupt lines |
| emr_req_o | output | 1 | Request a write of the extended mode register |
| emr_data_o | output | EMR_W | Value to write (termination off) |
| emr_ack_i | input | 1 | Extended mode register write complete |
| sr_req_o | output | 1 | Hold DRAM in self refresh |
| sr_ack_i | input | 1 | DRAM is in self refresh |
| ctl_pwr_off_o | output | 1 | Power down the DRAM controller |
| ctl_pwr_good_i | input | 1 | DRAM controller power is good |
| clk_xtal_sel_o | output | 1 | Select crystal as system clock |
| clk_xtal_ack_i | input | 1 | Clock mux reports crystal in use |
| pll_pwr_off_o | output | 1 | Power down the PLL |
| pll_lock_i | input | 1 | PLL locked |
| cdel_en_o | output | 1 | Enable clock deletion |
| cdel_ack_i | input | 1 | Clock deleter reports active |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when exit completes |
| err_o | output | 1 | Step timeout occurred in the last run |

## Verification
The hardest situation to reach is a timeout on one of the exit steps. It needs a full entry, a wake, and then one slow peripheral only on the way back. The bench's status models take a latency per peripheral. After the wait state is reached and before the wake interrupt, the bench raises one model's latency to exactly the timeout, so only that exit step stalls. The latency sweep also runs a case at one cycle under the limit to check that the boundary passes.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EMR,
    ST_SR_ON,
    ST_CTL_OFF,
    ST_XTAL,
    ST_PLL_OFF,
    ST_CDEL_ON,
    ST_WAIT,
    ST_PLL_ON,
    ST_CDEL_OFF,
    ST_PLL_SEL,
    ST_CTL_ON,
    ST_SR_OFF
  } sseq_state_e;

  typedef struct packed {
    logic emr;
    logic sr;
    logic ctl_off;
    logic xtal;
    logic pll_off;
    logic cdel;
  } sseq_ctrl_t;

  // request levels held in each state
  function automatic sseq_ctrl_t ctrl_of(input sseq_state_e s);
    sseq_ctrl_t c;
    c = '0;
    case (s)
      ST_EMR:      c.emr = 1'b1;
      ST_SR_ON:    c.sr = 1'b1;
      ST_CTL_OFF:  begin c.sr = 1'b1; c.ctl_off = 1'b1; end
      ST_XTAL:     begin c.sr = 1'b1; c.ctl_off = 1'b1; c.xtal = 1'b1; end
      ST_PLL_OFF:  begin c.sr = 1'b1; c.ctl_off = 1'b1; c.xtal = 1'b1; c.pll_off = 1'b1; end
      ST_CDEL_ON,
      ST_WAIT:     begin c.sr = 1'b1; c.ctl_off = 1'b1; c.xtal = 1'b1; c.pll_off = 1'b1;
                         c.cdel = 1'b1; end
      ST_PLL_ON:   begin c.sr = 1'b1; c.ctl_off = 1'b1; c.xtal = 1'b1; c.cdel = 1'b1; end
      ST_CDEL_OFF: begin c.sr = 1'b1; c.ctl_off = 1'b1; c.xtal = 1'b1; end
      ST_PLL_SEL:  begin c.sr = 1'b1; c.ctl_off = 1'b1; end
      ST_CTL_ON:   c.sr = 1'b1;
      default:     c = '0;
    endcase
    return c;
  endfunction

  function automatic logic is_step(input sseq_state_e s);
    return (s != ST_IDLE) && (s != ST_WAIT);
  endfunction

  function automatic sseq_state_e succ_of(input sseq_state_e s);
    case (s)
      ST_EMR:      return ST_SR_ON;
      ST_SR_ON:    return ST_CTL_OFF;
      ST_CTL_OFF:  return ST_XTAL;
      ST_XTAL:     return ST_PLL_OFF;
      ST_PLL_OFF:  return ST_CDEL_ON;
      ST_CDEL_ON:  return ST_WAIT;
      ST_WAIT:     return ST_PLL_ON;
      ST_PLL_ON:   return ST_CDEL_OFF;
      ST_CDEL_OFF: return ST_PLL_SEL;
      ST_PLL_SEL:  return ST_CTL_ON;
      ST_CTL_ON:   return ST_SR_OFF;
      default:     return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sseq_ack_sel.sv
module sseq_ack_sel
  import sseq_pkg::*;
(
  input  sseq_state_e state,
  input  logic        emr_ack_i,
  input  logic        sr_ack_i,
  input  logic        ctl_pwr_good_i,
  input  logic        clk_xtal_ack_i,
  input  logic        pll_lock_i,
  input  logic        cdel_ack_i,
  output logic        ok_o
);

  always_comb begin
    case (state)
      ST_EMR:      ok_o = emr_ack_i;
      ST_SR_ON:    ok_o = sr_ack_i;
      ST_CTL_OFF:  ok_o = ~ctl_pwr_good_i;
      ST_XTAL:     ok_o = clk_xtal_ack_i;
      ST_PLL_OFF:  ok_o = ~pll_lock_i;
      ST_CDEL_ON:  ok_o = cdel_ack_i;
      ST_PLL_ON:   ok_o = pll_lock_i;
      ST_CDEL_OFF: ok_o = ~cdel_ack_i;
      ST_PLL_SEL:  ok_o = ~clk_xtal_ack_i;
      ST_CTL_ON:   ok_o = ctl_pwr_good_i;
      ST_SR_OFF:   ok_o = ~sr_ack_i;
      default:     ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sseq_timeout.sv
module sseq_timeout #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic active_i,
  output logic expired_o
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt <= '0;
    end else if (active_i && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired_o = active_i && (cnt == LIM);

endmodule

// File: rtl/sseq_wake.sv
module sseq_wake #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [IRQ_W-1:0] mask_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic             arm_i,
  output logic             wake_o
);

  logic [IRQ_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= mask_i;
    end
  end

  assign wake_o = arm_i && |(irq_i & mask_q);

endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
#(
  parameter int              EMR_W        = 16,
  parameter logic [EMR_W-1:0] EMR_TERM_OFF = 16'h0004
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic             expired_i,
  input  logic             wake_i,
  output sseq_state_e      state_o,
  output logic             adv_o,
  output logic             load_o,
  output sseq_ctrl_t       ctrl_o,
  output logic [EMR_W-1:0] emr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  sseq_state_e state, state_n;
  logic        fail;
  sseq_ctrl_t  c_n;

  always_comb begin
    state_n = state;
    fail    = 1'b0;
    if (state == ST_IDLE) begin
      if (start_i) state_n = ST_EMR;
    end else if (state == ST_WAIT) begin
      if (wake_i) state_n = ST_PLL_ON;
    end else if (ok_i) begin
      state_n = succ_of(state);
    end else if (expired_i) begin
      state_n = ST_IDLE;
      fail    = 1'b1;
    end
  end

  assign c_n = ctrl_of(state_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ctrl_o     <= '0;
      emr_data_o <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      state      <= state_n;
      ctrl_o     <= c_n;
      emr_data_o <= c_n.emr ? EMR_TERM_OFF : '0;
      busy_o     <= (state_n != ST_IDLE);
      done_o     <= (state == ST_SR_OFF) && ok_i;
      if (fail) begin
        err_o <= 1'b1;
      end else if (load_o) begin
        err_o <= 1'b0;
      end
    end
  end

  assign state_o = state;
  assign adv_o   = (state_n != state);
  assign load_o  = (state == ST_IDLE) && start_i;

endmodule

// File: rtl/standby_seq.sv
module standby_seq
  import sseq_pkg::*;
#(
  parameter int               IRQ_W        = 4,
  parameter int               EMR_W        = 16,
  parameter logic [EMR_W-1:0] EMR_TERM_OFF = 16'h0004,
  parameter int               TMO_CYC      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IRQ_W-1:0] trig_mask_i,
  input  logic [IRQ_W-1:0] irq_i,
  output logic             emr_req_o,
  output logic [EMR_W-1:0] emr_data_o,
  input  logic             emr_ack_i,
  output logic             sr_req_o,
  input  logic             sr_ack_i,
  output logic             ctl_pwr_off_o,
  input  logic             ctl_pwr_good_i,
  output logic             clk_xtal_sel_o,
  input  logic             clk_xtal_ack_i,
  output logic             pll_pwr_off_o,
  input  logic             pll_lock_i,
  output logic             cdel_en_o,
  input  logic             cdel_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  sseq_state_e state;
  sseq_ctrl_t  ctrl;
  logic        ok, expired, wake, adv, load;

  sseq_ack_sel u_ack (
    .state          (state),
    .emr_ack_i      (emr_ack_i),
    .sr_ack_i       (sr_ack_i),
    .ctl_pwr_good_i (ctl_pwr_good_i),
    .clk_xtal_ack_i (clk_xtal_ack_i),
    .pll_lock_i     (pll_lock_i),
    .cdel_ack_i     (cdel_ack_i),
    .ok_o           (ok)
  );

  sseq_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk       (clk),
    .rst       (rst),
    .restart_i (adv),
    .active_i  (is_step(state)),
    .expired_o (expired)
  );

  sseq_wake #(.IRQ_W(IRQ_W)) u_wake (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .mask_i (trig_mask_i),
    .irq_i  (irq_i),
    .arm_i  (state == ST_WAIT),
    .wake_o (wake)
  );

  sseq_fsm #(.EMR_W(EMR_W), .EMR_TERM_OFF(EMR_TERM_OFF)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ok_i       (ok),
    .expired_i  (expired),
    .wake_i     (wake),
    .state_o    (state),
    .adv_o      (adv),
    .load_o     (load),
    .ctrl_o     (ctrl),
    .emr_data_o (emr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign emr_req_o      = ctrl.emr;
  assign sr_req_o       = ctrl.sr;
  assign ctl_pwr_off_o  = ctrl.ctl_off;
  assign clk_xtal_sel_o = ctrl.xtal;
  assign pll_pwr_off_o  = ctrl.pll_off;
  assign cdel_en_o      = ctrl.cdel;

endmodule

// File: rtl/sseq_chk.sv
module sseq_chk (
  input logic clk,
  input logic rst,
  input logic sr_req_o,
  input logic ctl_pwr_off_o,
  input logic clk_xtal_sel_o,
  input logic pll_pwr_off_o,
  input logic cdel_en_o,
  input logic pll_lock_i,
  input logic ctl_pwr_good_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  AST_CTL_OFF_IN_SR: assert property (@(posedge clk) disable iff (rst)
    ctl_pwr_off_o |-> sr_req_o); // R3
  AST_PLL_OFF_ON_XTAL: assert property (@(posedge clk) disable iff (rst)
    pll_pwr_off_o |-> clk_xtal_sel_o); // R4
  AST_CDEL_ON_XTAL: assert property (@(posedge clk) disable iff (rst)
    cdel_en_o |-> clk_xtal_sel_o); // R5
  AST_PLL_UP_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($fell(pll_pwr_off_o) && !err_o) |-> ctl_pwr_off_o); // R7
  AST_PLL_RESEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_xtal_sel_o) && !err_o) |-> $past(pll_lock_i)); // R7
  AST_SR_EXIT_PG: assert property (@(posedge clk) disable iff (rst)
    ($fell(sr_req_o) && !err_o) |-> $past(ctl_pwr_good_i)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !sr_req_o)); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o); // R9

endmodule

bind standby_seq sseq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .sr_req_o       (sr_req_o),
  .ctl_pwr_off_o  (ctl_pwr_off_o),
  .clk_xtal_sel_o (clk_xtal_sel_o),
  .pll_pwr_off_o  (pll_pwr_off_o),
  .cdel_en_o      (cdel_en_o),
  .pll_lock_i     (pll_lock_i),
  .ctl_pwr_good_i (ctl_pwr_good_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/test_standby_seq.sv
module test_standby_seq;

  localparam int IRQ_W = 4;
  localparam int EMR_W = 16;
  localparam logic [EMR_W-1:0] EMR_VAL = 16'h00A4;
  localparam int TMO = 8;
  localparam int NEVT = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [IRQ_W-1:0] trig_mask_i = '0;
  logic [IRQ_W-1:0] irq_i = '0;
  logic emr_req_o, sr_req_o, ctl_pwr_off_o, clk_xtal_sel_o, pll_pwr_off_o, cdel_en_o;
  logic [EMR_W-1:0] emr_data_o;
  logic busy_o, done_o, err_o;
  logic [5:0] want, ackv;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int lat [6];
  int ev [NEVT];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  standby_seq #(.IRQ_W(IRQ_W), .EMR_W(EMR_W), .EMR_TERM_OFF(EMR_VAL), .TMO_CYC(TMO))
  i_standby_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .trig_mask_i(trig_mask_i), .irq_i(irq_i),
    .emr_req_o(emr_req_o), .emr_data_o(emr_data_o), .emr_ack_i(ackv[0]),
    .sr_req_o(sr_req_o), .sr_ack_i(ackv[1]),
    .ctl_pwr_off_o(ctl_pwr_off_o), .ctl_pwr_good_i(ackv[2]),
    .clk_xtal_sel_o(clk_xtal_sel_o), .clk_xtal_ack_i(ackv[3]),
    .pll_pwr_off_o(pll_pwr_off_o), .pll_lock_i(ackv[4]),
    .cdel_en_o(cdel_en_o), .cdel_ack_i(ackv[5]),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // status models: each follows its wanted level lat[i] cycles after a change
  assign want = {cdel_en_o, ~pll_pwr_off_o, clk_xtal_sel_o, ~ctl_pwr_off_o, sr_req_o, emr_req_o};

  for (genvar g = 0; g < 6; g++) begin : g_model
    int cnt;
    always @(posedge clk) begin
      if (rst) begin
        ackv[g] <= (g == 2 || g == 4);
        cnt <= 0;
      end else if (want[g] != ackv[g]) begin
        if (cnt >= lat[g] - 1) begin
          ackv[g] <= want[g];
          cnt <= 0;
        end else begin
          cnt <= cnt + 1;
        end
      end else begin
        cnt <= 0;
      end
    end
  end

  // event stamps taken away from the clock edge
  logic p_emr = 0, p_sr = 0, p_ctl = 0, p_xt = 0, p_pll = 0, p_cd = 0, p_err = 0;
  always @(negedge clk) begin
    if (emr_req_o && !p_emr) ev[0] = cyc;
    if (sr_req_o && !p_sr) ev[1] = cyc;
    if (ctl_pwr_off_o && !p_ctl) ev[2] = cyc;
    if (clk_xtal_sel_o && !p_xt) ev[3] = cyc;
    if (pll_pwr_off_o && !p_pll) ev[4] = cyc;
    if (cdel_en_o && !p_cd) ev[5] = cyc;
    if (!pll_pwr_off_o && p_pll && !err_o) ev[6] = cyc;
    if (!cdel_en_o && p_cd && !err_o) ev[7] = cyc;
    if (!clk_xtal_sel_o && p_xt && !err_o) ev[8] = cyc;
    if (!ctl_pwr_off_o && p_ctl && !err_o) ev[9] = cyc;
    if (!sr_req_o && p_sr && !err_o) ev[10] = cyc;
    if (done_o) ev[11] = cyc;
    if (err_o && !p_err) ev[12] = cyc;
    p_emr = emr_req_o; p_sr = sr_req_o; p_ctl = ctl_pwr_off_o;
    p_xt = clk_xtal_sel_o; p_pll = pll_pwr_off_o; p_cd = cdel_en_o; p_err = err_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ev(input int k);
    while (ev[k] < 0) @(negedge clk);
  endtask

  function automatic int exit_ev(input int k);
    case (k)
      4: return 6;
      5: return 7;
      3: return 8;
      2: return 9;
      default: return 10;
    endcase
  endfunction

  // one sequence: tk = model index to stall, ex = stall on exit path
  task automatic run(input int m, input int wb, input int tk, input bit ex, input int base);
    int tw;
    for (int i = 0; i < NEVT; i++) ev[i] = -1;
    for (int i = 0; i < 6; i++) lat[i] = (base > 0) ? base : 1 + ((m + 3 * i) % (TMO - 1));
    if (!ex && tk >= 0) lat[tk] = TMO;
    @(negedge clk);
    start_i = 1'b1; trig_mask_i = IRQ_W'(m);
    @(negedge clk);
    start_i = 1'b0; trig_mask_i = '0;
    chk("R9 err cleared on start", err_o, 0);
    chk("R2 busy after start", busy_o, 1);
    chk("R2 emr data", int'(emr_data_o), int'(EMR_VAL));
    if (!ex && tk >= 0) begin
      wait_ev(12);
      chk("R9 entry timeout cycle", ev[12] - ev[tk], TMO);
      chk("R9 idle after timeout", {busy_o, emr_req_o, sr_req_o, ctl_pwr_off_o,
          clk_xtal_sel_o, pll_pwr_off_o, cdel_en_o}, 0);
      repeat (3 * TMO + 4) @(negedge clk);
      return;
    end
    wait_ev(5);
    repeat (lat[5] + 3) @(negedge clk);
    // start while busy must not change the captured mask
    start_i = 1'b1; trig_mask_i = '1;
    @(negedge clk);
    start_i = 1'b0; trig_mask_i = '0;
    if ((~m & ((1 << IRQ_W) - 1)) != 0) begin
      irq_i = IRQ_W'(~m);
      repeat (4) @(negedge clk);
      chk("R6 masked irq ignored", {busy_o, pll_pwr_off_o}, 2'b11);
      chk("R2 start while busy ignored", ev[6], -1);
      irq_i = '0;
    end
    if (ex) lat[tk] = TMO;
    @(negedge clk);
    irq_i = IRQ_W'(1 << wb);
    tw = cyc + 1;
    @(negedge clk);
    irq_i = '0;
    if (ex) begin
      wait_ev(12);
      chk("R9 exit timeout cycle", ev[12] - ev[exit_ev(tk)], TMO);
      chk("R9 idle after exit timeout", {busy_o, sr_req_o, ctl_pwr_off_o,
          clk_xtal_sel_o, pll_pwr_off_o, cdel_en_o}, 0);
      repeat (3 * TMO + 4) @(negedge clk);
      return;
    end
    wait_ev(11);
    chk("R3 sr after emr ack", ev[1] - ev[0], lat[0] + 1);
    chk("R3 ctl off after sr ack", ev[2] - ev[1], lat[1] + 1);
    chk("R4 xtal after pg low", ev[3] - ev[2], lat[2] + 1);
    chk("R4 pll off after mux ack", ev[4] - ev[3], lat[3] + 1);
    chk("R5 cdel after lock low", ev[5] - ev[4], lat[4] + 1);
    chk("R6 wake edge", ev[6], tw);
    chk("R7 cdel off after lock", ev[7] - ev[6], lat[4] + 1);
    chk("R7 pll reselect after cdel ack", ev[8] - ev[7], lat[5] + 1);
    chk("R8 ctl on after mux ack", ev[9] - ev[8], lat[3] + 1);
    chk("R8 sr exit after pg", ev[10] - ev[9], lat[2] + 1);
    chk("R8 done after sr ack low", ev[11] - ev[10], lat[1] + 1);
    chk("R8 idle at done", busy_o, 0);
    repeat (TMO + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) lat[i] = 1;
    for (int i = 0; i < NEVT; i++) ev[i] = -1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {emr_req_o, sr_req_o, ctl_pwr_off_o, clk_xtal_sel_o,
        pll_pwr_off_o, cdel_en_o, busy_o, done_o, err_o}, 0);
    chk("R1 reset data", int'(emr_data_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int m = 1; m < (1 << IRQ_W); m++) begin
      int wb = 0;
      for (int b = 0; b < IRQ_W; b++)
        if (m[b] && (m % 2 == 1 || wb == 0 && !m[wb])) wb = b;
      if (!m[wb]) wb = $clog2(m & -m);
      run(m, wb, -1, 1'b0, 0);
    end
    run(5, 2, -1, 1'b0, TMO - 1);                     // boundary latency passes
    for (int k = 0; k < 6; k++) run(3, 1, k, 1'b0, 0);  // entry stalls
    run(6, 1, 4, 1'b1, 0);
    run(6, 2, 5, 1'b1, 0);
    run(9, 0, 3, 1'b1, 0);
    run(9, 3, 2, 1'b1, 0);
    run(12, 2, 1, 1'b1, 0);
    run(2, 1, -1, 1'b0, 0);                            // recovery after errors
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule